// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps a 512-row dynamic RAM alive and brings it up safely. After reset it keeps the memory untouched for a programmable pause. It then drives a burst of dummy RAS strobes and only then declares the memory ready. From that point a free-running interval timer creates one refresh obligation per period. The default period is about 15.6 µs at 100 MHz, so all 512 rows are covered every 8 ms.

Each obligation is offered to the access controller as a request. When the controller grants, the block takes over the strobes for one refresh cycle. Obligations that arrive while a grant is delayed are held in a small backlog and served one by one. If the backlog is already full when another one arrives, the refresh interval has been exceeded. The block then drops ready and runs the whole pause-plus-dummy-strobe start-up again.

A build-time parameter selects the refresh style. In CAS-before-RAS style the memory supplies the row itself, and the block only shapes the strobes. In RAS-only style the block drives a row address from its own counter, which advances after every strobe and wraps from 511 to 0.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and for INIT_PAUSE clock cycles after it is released, ras_n and cas_n stay high, and ready and ref_req stay low.
- R2: After the pause, exactly INIT_STROBES RAS strobes are issued back to back without any grant, and ready rises only after the last of them has finished its precharge.
- R3: In CAS-before-RAS mode (RAS_ONLY=0), cas_n falls while ras_n is high, T_SET cycles before ras_n falls, and stays low for T_CHR cycles after ras_n falls.
- R4: Every strobe holds ras_n low for exactly T_LOW cycles, followed by T_RP cycles with ras_n and cas_n both high before the next strobe can start.
- R5: In RAS-only mode (RAS_ONLY=1), cas_n never goes low and row_addr starts at 0 after reset. row_addr changes only at the end of a strobe, by +1 modulo ROWS, so 511 is followed by 0.
- R6: Once ready, one refresh obligation is added every TICKS_PER_REF cycles. ref_req is high exactly while ready is high, no refresh strobe is running, and at least one obligation is pending.
- R7: A refresh strobe starts only in the cycle after ref_gnt is sampled high together with ref_req. ref_req is low for the whole strobe, and ref_gnt sampled while ref_req is low starts nothing.
- R8: At most BACKLOG_MAX obligations are held. A delayed grant serves each held obligation with its own strobe, one after another, until ref_req falls.
- R9: When an obligation arrives while BACKLOG_MAX are already held and no grant is taken in that cycle, ready falls in the next cycle. The block then repeats the pause and the INIT_STROBES dummy strobes before ready rises again.
- R10: In CAS-before-RAS mode row_addr is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller hands the memory strobes to this block |
| ref_req | output | 1 | At least one refresh is pending and the block is idle |
| ready | output | 1 | Start-up finished; the memory may be accessed between refreshes |
| ras_n | output | 1 | Row strobe to the memory, active low |
| cas_n | output | 1 | Column strobe to the memory, active low |
| row_addr | output | ROW_W | Row address for RAS-only refresh; 0 in CAS-before-RAS mode |

## Verification
The properties take ref_gnt to be a level that the controller may raise at any time. They rely only on the block ignoring it outside the idle-and-requesting state. The pulse-width properties also assume INIT_PAUSE is longer than one strobe, so a restart caused by a backlog overflow never overlaps a strobe in flight. The stimulus grants with no delay, with a fixed delay, and never. It adds one stray grant pulse while no request is pending, and it drives two instances, one per refresh style, with the same pattern. The grant-starved phase is long enough to push the backlog into overflow and through a complete restart.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    SEQ_PAUSE   = 2'd0,
    SEQ_WARM    = 2'd1,
    SEQ_IDLE    = 2'd2,
    SEQ_REFRESH = 2'd3
  } seq_state_t;

  // RAS is low from position t_set for t_low positions of one strobe.
  function automatic logic ras_window(input int pos, input int t_set, input int t_low);
    return (pos >= t_set) && (pos < t_set + t_low);
  endfunction

  // In CAS-before-RAS style CAS leads RAS by t_set and trails its fall by t_chr.
  function automatic logic cas_window(input int pos, input int t_set, input int t_chr);
    return (pos >= 0) && (pos < t_set + t_chr);
  endfunction

  function automatic int strobe_len(input int t_set, input int t_low, input int t_rp);
    return t_set + t_low + t_rp;
  endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int TICKS_PER_REF = 1562,
  parameter int BACKLOG_MAX   = 4,
  localparam int TICK_W = $clog2(TICKS_PER_REF),
  localparam int PEND_W = $clog2(BACKLOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              take,
  output logic              tick,
  output logic              overflow,
  output logic              pending,
  output logic [PEND_W-1:0] pend
);

  logic [TICK_W-1:0] cnt_q;
  logic [PEND_W-1:0] pend_q;

  assign tick     = run && (cnt_q == TICK_W'(TICKS_PER_REF - 1));
  assign overflow = tick && (pend_q == PEND_W'(BACKLOG_MAX)) && !take;
  assign pending  = (pend_q != '0);
  assign pend     = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (!run || overflow) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      case ({tick, take})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

endmodule

// File: rtl/dram_rfsh_strobe.sv
module dram_rfsh_strobe
  import dram_rfsh_pkg::*;
#(
  parameter int T_SET    = 2,
  parameter int T_LOW    = 5,
  parameter int T_CHR    = 2,
  parameter int T_RP     = 4,
  parameter int RAS_ONLY = 0,
  parameter int ROWS     = 512,
  localparam int ROW_W = $clog2(ROWS),
  localparam int LEN   = strobe_len(T_SET, T_LOW, T_RP),
  localparam int POS_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);

  logic             active_q;
  logic [POS_W-1:0] pos_q;
  logic             ras_low;
  logic             cas_low;

  assign done = active_q && (pos_q == POS_W'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (done) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (active_q) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign ras_low = active_q && ras_window(int'(pos_q), T_SET, T_LOW);
  assign ras_n   = ~ras_low;
  assign cas_n   = ~cas_low;

  generate
    if (RAS_ONLY != 0) begin : g_ras_only
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row_q <= '0;
        else if (done) row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end
      assign row_addr = row_q;
      assign cas_low  = 1'b0;
    end else begin : g_cbr
      assign row_addr = '0;
      assign cas_low  = active_q && cas_window(int'(pos_q), T_SET, T_CHR);
    end
  endgenerate

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int ROWS          = 512,
  parameter int TICKS_PER_REF = 1562,
  parameter int INIT_PAUSE    = 20000,
  parameter int INIT_STROBES  = 8,
  parameter int BACKLOG_MAX   = 4,
  parameter int T_SET         = 2,
  parameter int T_LOW         = 5,
  parameter int T_CHR         = 2,
  parameter int T_RP          = 4,
  parameter int RAS_ONLY      = 0,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int PAUSE_W = $clog2(INIT_PAUSE),
  localparam int WARM_W  = $clog2(INIT_STROBES + 1),
  localparam int PEND_W  = $clog2(BACKLOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row_addr
);

  seq_state_t         state_q, state_d;
  logic [PAUSE_W-1:0] pause_q;
  logic [WARM_W-1:0]  warm_q;

  // Named internal events, also observed by the bound checker.
  logic              strobe_start;
  logic              strobe_done;
  logic              grant_take;
  logic              tick;
  logic              overflow;
  logic              pending;
  logic              run;
  logic [PEND_W-1:0] pend;

  assign run     = (state_q == SEQ_IDLE) || (state_q == SEQ_REFRESH);
  assign ready   = run;
  assign ref_req = (state_q == SEQ_IDLE) && pending;

  always_comb begin
    state_d      = state_q;
    strobe_start = 1'b0;
    grant_take   = 1'b0;
    case (state_q)
      SEQ_PAUSE: begin
        if (pause_q == PAUSE_W'(INIT_PAUSE - 1)) begin
          strobe_start = 1'b1;
          state_d      = SEQ_WARM;
        end
      end
      SEQ_WARM: begin
        if (strobe_done) begin
          if (warm_q == WARM_W'(INIT_STROBES - 1)) state_d = SEQ_IDLE;
          else                                    strobe_start = 1'b1;
        end
      end
      SEQ_IDLE: begin
        if (ref_gnt && pending) begin
          strobe_start = 1'b1;
          grant_take   = 1'b1;
          state_d      = SEQ_REFRESH;
        end
      end
      SEQ_REFRESH: begin
        if (strobe_done) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_PAUSE;
    endcase
    if (overflow) state_d = SEQ_PAUSE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_PAUSE;
      pause_q <= '0;
      warm_q  <= '0;
    end else begin
      state_q <= state_d;
      pause_q <= (state_q == SEQ_PAUSE && state_d == SEQ_PAUSE) ? pause_q + 1'b1 : '0;
      if (state_q != SEQ_WARM)  warm_q <= '0;
      else if (strobe_done)     warm_q <= warm_q + 1'b1;
    end
  end

  dram_rfsh_timer #(
    .TICKS_PER_REF(TICKS_PER_REF),
    .BACKLOG_MAX  (BACKLOG_MAX)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .take    (grant_take),
    .tick    (tick),
    .overflow(overflow),
    .pending (pending),
    .pend    (pend)
  );

  dram_rfsh_strobe #(
    .T_SET   (T_SET),
    .T_LOW   (T_LOW),
    .T_CHR   (T_CHR),
    .T_RP    (T_RP),
    .RAS_ONLY(RAS_ONLY),
    .ROWS    (ROWS)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (strobe_start),
    .done    (strobe_done),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .row_addr(row_addr)
  );

endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
  parameter int T_LOW        = 5,
  parameter int T_RP         = 4,
  parameter int INIT_STROBES = 8,
  parameter int BACKLOG_MAX  = 4,
  parameter int RAS_ONLY     = 0,
  parameter int ROW_W        = 9,
  parameter int PEND_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ready,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             overflow,
  input logic             strobe_start,
  input logic [PEND_W-1:0] pend
);

  logic [7:0] low_run;
  logic [7:0] high_run;
  logic [7:0] init_falls;
  logic       ras_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= 8'd0;
      high_run   <= 8'd0;
      init_falls <= 8'd0;
      ras_prev   <= 1'b1;
    end else begin
      ras_prev <= ras_n;
      if (!ras_n) begin
        low_run  <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
        high_run <= 8'd0;
      end else begin
        low_run  <= 8'd0;
        high_run <= (high_run == 8'hFF) ? high_run : high_run + 8'd1;
      end
      if (ready)                  init_falls <= 8'd0;
      else if (ras_prev && !ras_n) init_falls <= (init_falls == 8'hFF) ? init_falls : init_falls + 8'd1;
    end
  end

  AST_INIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (int'(init_falls) >= INIT_STROBES)); // R2
  AST_CBR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((RAS_ONLY == 0) && $fell(ras_n)) |-> (!cas_n && $past(!cas_n))); // R3
  AST_CAS_FALLS_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    ((RAS_ONLY == 0) && $fell(cas_n)) |-> ras_n); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (int'(low_run) == T_LOW)); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (int'(high_run) >= T_RP)); // R4
  AST_RASONLY_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY != 0) |-> cas_n); // R5
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != $past(row_addr)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1))); // R5
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready); // R6
  AST_GRANT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> !ref_req); // R7
  AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_start && ready) |-> (ref_req && ref_gnt)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= BACKLOG_MAX); // R8
  AST_OVERFLOW_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !ready); // R9
  AST_CBR_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY == 0) |-> (row_addr == '0)); // R10

endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(
  .T_LOW       (T_LOW),
  .T_RP        (T_RP),
  .INIT_STROBES(INIT_STROBES),
  .BACKLOG_MAX (BACKLOG_MAX),
  .RAS_ONLY    (RAS_ONLY),
  .ROW_W       (ROW_W),
  .PEND_W      (PEND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_gnt     (ref_gnt),
  .ref_req     (ref_req),
  .ready       (ready),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .row_addr    (row_addr),
  .overflow    (overflow),
  .strobe_start(strobe_start),
  .pend        (pend)
);

// File: tb/dram_rfsh_model.sv
module dram_rfsh_model #(
  parameter int ROWS = 512, parameter int TICKS = 60, parameter int PAUSE = 40,
  parameter int NSTR = 8, parameter int BMAX = 3, parameter int TS = 2,
  parameter int TL = 5, parameter int TC = 2, parameter int TP = 3, parameter int RO = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  output logic exp_ras_n,
  output logic exp_cas_n,
  output logic exp_req,
  output logic exp_ready,
  output logic [$clog2(ROWS)-1:0] exp_row,
  output int   exp_pend
);
  // phase: 0 waiting out the pause, 1 dummy strobes, 2 idle, 3 refreshing
  int phase, waited, dummies, pos, owed, elapsed, row, nxt;
  bit  is_ready, fin, go, took, tk;
  localparam int SPAN = TS + TL + TP;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; waited = 0; dummies = 0; pos = -1; owed = 0; elapsed = 0; row = 0;
    end else begin
      is_ready = (phase >= 2);
      fin  = (pos == SPAN - 1);
      go   = 0; took = 0; nxt = phase;
      if (phase == 0) begin
        if (waited == PAUSE - 1) begin go = 1; nxt = 1; dummies = 0; end
        else waited++;
      end else if (phase == 1) begin
        if (fin) begin
          if (dummies == NSTR - 1) nxt = 2;
          else begin dummies++; go = 1; end
        end
      end else if (phase == 2) begin
        if (gnt && owed > 0) begin go = 1; took = 1; nxt = 3; end
      end else if (fin) nxt = 2;
      tk = is_ready && (elapsed == TICKS - 1);
      if (!is_ready) begin elapsed = 0; owed = 0; end
      else if (tk && owed == BMAX && !took) begin nxt = 0; waited = 0; elapsed = 0; owed = 0; end
      else begin
        elapsed = tk ? 0 : elapsed + 1;
        owed = owed + (tk ? 1 : 0) - (took ? 1 : 0);
      end
      if (fin && RO != 0) row = (row + 1) % ROWS;
      if (go) pos = 0; else if (fin) pos = -1; else if (pos >= 0) pos++;
      phase = nxt;
    end
  end

  assign exp_ready = (phase >= 2);
  assign exp_req   = (phase == 2) && (owed > 0);
  assign exp_ras_n = !(pos >= TS && pos < TS + TL);
  assign exp_cas_n = (RO != 0) ? 1'b1 : !(pos >= 0 && pos < TS + TC);
  assign exp_row   = row[$clog2(ROWS)-1:0];
  assign exp_pend  = owed;
endmodule

// File: tb/dram_rfsh_seq_test.sv
module dram_rfsh_seq_test;
  localparam int ROWS = 512, TICKS = 60, PAUSE = 40, NSTR = 8, BMAX = 3;
  localparam int TS = 2, TL = 5, TC = 2, TP = 3;
  localparam int SPAN = TS + TL + TP;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic gnt_a, gnt_b;
  logic req_a, rdy_a, ras_a, cas_a, req_b, rdy_b, ras_b, cas_b;
  logic [8:0] row_a, row_b;
  logic xras_a, xcas_a, xreq_a, xrdy_a, xras_b, xcas_b, xreq_b, xrdy_b;
  logic [8:0] xrow_a, xrow_b;
  int xpend_a, xpend_b;

  int checks = 0, errors = 0, cycles = 0;
  int falls_a = 0, falls_b = 0, wait_a = 0, wait_b = 0;
  int dly = 0;
  bit pulse = 0, cmp_on = 0, prev_a = 1, prev_b = 1, done_flag = 0;

  dram_rfsh_seq #(.ROWS(ROWS), .TICKS_PER_REF(TICKS), .INIT_PAUSE(PAUSE), .INIT_STROBES(NSTR),
    .BACKLOG_MAX(BMAX), .T_SET(TS), .T_LOW(TL), .T_CHR(TC), .T_RP(TP), .RAS_ONLY(0)) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_a), .ref_req(req_a), .ready(rdy_a),
    .ras_n(ras_a), .cas_n(cas_a), .row_addr(row_a));

  dram_rfsh_seq #(.ROWS(ROWS), .TICKS_PER_REF(TICKS), .INIT_PAUSE(PAUSE), .INIT_STROBES(NSTR),
    .BACKLOG_MAX(BMAX), .T_SET(TS), .T_LOW(TL), .T_CHR(TC), .T_RP(TP), .RAS_ONLY(1)) uut_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_b), .ref_req(req_b), .ready(rdy_b),
    .ras_n(ras_b), .cas_n(cas_b), .row_addr(row_b));

  dram_rfsh_model #(.ROWS(ROWS), .TICKS(TICKS), .PAUSE(PAUSE), .NSTR(NSTR), .BMAX(BMAX),
    .TS(TS), .TL(TL), .TC(TC), .TP(TP), .RO(0)) mdl_a (
    .clk(clk), .rst_n(rst_n), .gnt(gnt_a), .exp_ras_n(xras_a), .exp_cas_n(xcas_a),
    .exp_req(xreq_a), .exp_ready(xrdy_a), .exp_row(xrow_a), .exp_pend(xpend_a));

  dram_rfsh_model #(.ROWS(ROWS), .TICKS(TICKS), .PAUSE(PAUSE), .NSTR(NSTR), .BMAX(BMAX),
    .TS(TS), .TL(TL), .TC(TC), .TP(TP), .RO(1)) mdl_b (
    .clk(clk), .rst_n(rst_n), .gnt(gnt_b), .exp_ras_n(xras_b), .exp_cas_n(xcas_b),
    .exp_req(xreq_b), .exp_ready(xrdy_b), .exp_row(xrow_b), .exp_pend(xpend_b));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Grant policy: grant after dly cycles of request, never when dly < 0; pulse forces a grant.
  always @(negedge clk) begin
    wait_a = req_a ? wait_a + 1 : 0;
    wait_b = req_b ? wait_b + 1 : 0;
    gnt_a = ((dly >= 0) && req_a && (wait_a > dly)) || pulse;
    gnt_b = ((dly >= 0) && req_b && (wait_b > dly)) || pulse;
  end

  // RAS fall counters and the cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (prev_a && !ras_a) falls_a++;
    if (prev_b && !ras_b) falls_b++;
    prev_a = ras_a;
    prev_b = ras_b;
    if (cmp_on && !done_flag) begin
      check(ras_a == xras_a, "R4", "cbr ras_n", int'(ras_a), int'(xras_a));
      check(cas_a == xcas_a, "R3", "cbr cas_n", int'(cas_a), int'(xcas_a));
      check(req_a == xreq_a, "R6", "cbr ref_req", int'(req_a), int'(xreq_a));
      check(rdy_a == xrdy_a, "R2", "cbr ready", int'(rdy_a), int'(xrdy_a));
      check(row_a == xrow_a, "R10", "cbr row_addr", int'(row_a), int'(xrow_a));
      check(ras_b == xras_b, "R4", "ras-only ras_n", int'(ras_b), int'(xras_b));
      check(cas_b == xcas_b, "R5", "ras-only cas_n", int'(cas_b), int'(xcas_b));
      check(req_b == xreq_b, "R7", "ras-only ref_req", int'(req_b), int'(xreq_b));
      check(rdy_b == xrdy_b, "R9", "ras-only ready", int'(rdy_b), int'(xrdy_b));
      check(row_b == xrow_b, "R5", "ras-only row_addr", int'(row_b), int'(xrow_b));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      finish_run();
    end
  end

  initial begin
    int mark_a, mark_b, n;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(ras_a && cas_a && ras_b && cas_b, "R1", "strobes high in reset", int'(ras_a & cas_a & ras_b & cas_b), 1);
    check(!rdy_a && !req_a && !rdy_b && !req_b, "R1", "ready/req low in reset", int'(rdy_a | req_a | rdy_b | req_b), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (PAUSE - 1) @(negedge clk);
    check(falls_a == 0 && falls_b == 0, "R1", "no strobe during pause", falls_a + falls_b, 0);
    check(!rdy_a && !rdy_b, "R1", "not ready during pause", int'(rdy_a | rdy_b), 0);

    n = 0;
    while (!rdy_a && n < 400) begin @(negedge clk); n++; end
    check(rdy_a && rdy_b, "R2", "ready after warm-up", int'(rdy_a & rdy_b), 1);
    check(falls_a == NSTR, "R2", "cbr dummy strobes", falls_a, NSTR);
    check(falls_b == NSTR, "R2", "ras-only dummy strobes", falls_b, NSTR);
    check(row_b == 9'(NSTR), "R5", "row after dummy strobes", int'(row_b), NSTR);
    check(row_a == 9'd0, "R10", "cbr row held 0", int'(row_a), 0);

    // R6: immediate grants, one refresh per interval
    dly = 0;
    mark_a = falls_a;
    repeat (3 * TICKS + 15) @(negedge clk);
    check(falls_a - mark_a == 3, "R6", "refreshes in three intervals", falls_a - mark_a, 3);

    // R8: delayed grants are still served
    dly = 7;
    mark_a = falls_a;
    repeat (2 * TICKS + 25) @(negedge clk);
    check(falls_a - mark_a == 2, "R8", "refreshes with delayed grant", falls_a - mark_a, 2);

    // R7: stray grant while no request
    check(!req_a && !req_b, "R7", "no request before stray grant", int'(req_a | req_b), 0);
    mark_a = falls_a; mark_b = falls_b;
    pulse = 1; @(negedge clk); pulse = 0;
    repeat (15) @(negedge clk);
    check(falls_a == mark_a && falls_b == mark_b, "R7", "stray grant starts nothing", falls_a - mark_a + falls_b - mark_b, 0);

    // R8: backlog fills, then drains back to back
    dly = -1;
    n = 0;
    while (xpend_a != BMAX && n < 5 * TICKS) begin @(negedge clk); n++; end
    check(req_a && rdy_a, "R6", "request held while backlog pending", int'(req_a & rdy_a), 1);
    dly = 0;
    mark_a = falls_a; mark_b = falls_b;
    repeat (3 * SPAN + 10) @(negedge clk);
    check(falls_a - mark_a == BMAX, "R8", "backlog drained cbr", falls_a - mark_a, BMAX);
    check(falls_b - mark_b == BMAX, "R8", "backlog drained ras-only", falls_b - mark_b, BMAX);
    check(!req_a, "R8", "request cleared after drain", int'(req_a), 0);

    // R9: starve until the backlog overflows, then a full restart
    dly = -1;
    n = 0;
    while (rdy_a && n < 6 * TICKS) begin @(negedge clk); n++; end
    check(!rdy_a && !rdy_b, "R9", "ready dropped on overflow", int'(rdy_a | rdy_b), 0);
    mark_a = falls_a;
    n = 0;
    while (!rdy_a && n < 400) begin @(negedge clk); n++; end
    check(rdy_a, "R9", "ready again after restart", int'(rdy_a), 1);
    check(falls_a - mark_a == NSTR, "R9", "dummy strobes on restart", falls_a - mark_a, NSTR);
    check(int'(row_b) == (falls_b % ROWS), "R5", "row tracks strobes", int'(row_b), falls_b % ROWS);
    check(row_a == 9'd0, "R10", "cbr row still 0", int'(row_a), 0);

    done_flag = 1;
    finish_run();
  end
endmodule